// File: doc/BRIEF.md
# Flash command interface controller

This block is the command front end of a parallel NOR flash device, built over a small on-chip word array. Single-byte commands arrive on a write port. They choose what the read port returns: array words, identifier codes or a status byte. They also start a block erase. A read mode stays in force until another valid command arrives. Unknown codes leave the block as it was.

Block erase is a two-write sequence. A setup write comes first. It must be followed by a confirm write whose address falls inside the target block. The erase then runs for a parameter-set number of clock cycles and leaves every word of that block at all ones. During that time reads return status, bit 7 shows busy (0) or ready (1), and the write port is ignored. Error flags in the status byte are sticky until an explicit clear command. A bad sequence and an erase aimed at a write-protected block each raise their own pair of flags.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array mode, rd_data_o is 0, the status byte is 0x80, and word a of the array holds INIT_BASE + a (0xA500 + a by default).
- R2: In array mode, a read with rd_en_i high at a rising clock edge loads the word at rd_addr_i into rd_data_o at that edge. rd_data_o holds its value while rd_en_i is low.
- R3: Command 0x90 selects identifier mode. There, address 0 returns 0x0089, address 1 returns 0x88F1 + DEV_SEL, and any other address returns 0.
- R4: Status bits 5 (erase error), 4 (sequence error) and 1 (protect error) stay set until command 0x50 is accepted. Bit 3 always reads 0.
- R5: Command 0x50, accepted while not busy and not in erase setup, clears bits 5, 4 and 1 and selects array mode.
- R6: Command 0x20 followed by 0xD0 to an unprotected block erases that block only. Every word in it reads 0xFFFF afterwards, and the other blocks are unchanged.
- R7: After 0x20 and after an accepted 0xD0 the block is in status mode. A read sampled k cycles after the confirm edge shows bit 7 = 0 for 1 <= k <= ERASE_CYCLES and bit 7 = 1 from k = ERASE_CYCLES + 1.
- R8: While an erase is busy, every write, 0xFF included, is ignored. The mode and the error bits stay as they were.
- R9: Any write other than 0xD0 directly after 0x20 sets bits 5 and 4, erases nothing and leaves status mode selected.
- R10: 0xD0 after 0x20 to a block whose bit in LOCK_MASK is 1 sets bits 5 and 1 and erases nothing.
- R11: In status mode, the status byte is captured at the edge where rd_en_i is first seen high. That captured value is returned for as long as rd_en_i stays high.
- R12: Command codes other than 0xFF, 0x90, 0x70, 0x50 and 0x20 are ignored, and the current read mode persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Command write strobe, one cycle per command |
| wr_addr_i | input | AW | Write address, block field used by erase confirm |
| wr_data_i | input | 8 | Command byte |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Registered read data |

## Verification
A command is taken at the edge where wr_en_i is high, and its mode takes effect for a read at the next edge. Read data is registered at the edge where rd_en_i is high, so the bench raises the strobe at a falling edge and samples rd_data_o at the following falling edge. Between reads it keeps the strobe low for one cycle, so each read captures a fresh status. Erase timing is checked at the exact cycles k = ERASE_CYCLES and k = ERASE_CYCLES + 1 after the confirm edge. A strobe held across the end of an erase shows the captured status staying frozen until the strobe drops.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_ID     = 2'd1,
    MODE_STATUS = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_ID     = 8'h90;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_ERR   = 8'h50;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;

  localparam logic [15:0] MFR_CODE      = 16'h0089;
  localparam logic [15:0] DEV_CODE_BASE = 16'h88F1;
endpackage

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int ERASE_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(ERASE_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= CW'(ERASE_CYCLES);
    else if (cnt_q != '0)       cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int          BLOCKS      = 4,
  parameter int          BLOCK_WORDS = 8,
  parameter int          DW          = 16,
  parameter logic [DW-1:0] INIT_BASE = 16'hA500,
  localparam int         WORDS       = BLOCKS * BLOCK_WORDS,
  localparam int         AW          = $clog2(WORDS),
  localparam int         BW          = $clog2(BLOCK_WORDS),
  localparam int         BLK_W       = AW - BW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic             erase_i,
  input  logic [BLK_W-1:0] erase_blk_i
);
  logic [DW-1:0] mem_q [WORDS];

  // Whole-block erase lands in one edge at the end of the busy window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= INIT_BASE + DW'(i);
    end else if (erase_i) begin
      for (int i = 0; i < WORDS; i++)
        if (BLK_W'(i >> BW) == erase_blk_i) mem_q[i] <= '1;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int BLOCKS = 4,
  parameter logic [BLOCKS-1:0] LOCK_MASK = '0,
  localparam int BLK_W = $clog2(BLOCKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic [BLK_W-1:0] wr_blk_i,
  input  logic             busy_i,
  output rd_mode_e         mode_o,
  output logic             pend_o,
  output logic             start_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [7:0]       status_o
);
  rd_mode_e         mode_q;
  logic             pend_q, erase_err_q, seq_err_q, lock_err_q;
  logic [BLK_W-1:0] blk_q;
  logic             take;

  assign take    = wr_en_i && !busy_i;
  assign start_o = take && pend_q && (wr_data_i == CMD_CONFIRM) && !LOCK_MASK[wr_blk_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_ARRAY;
      pend_q      <= 1'b0;
      erase_err_q <= 1'b0;
      seq_err_q   <= 1'b0;
      lock_err_q  <= 1'b0;
      blk_q       <= '0;
    end else if (take) begin
      if (pend_q) begin
        pend_q <= 1'b0;
        mode_q <= MODE_STATUS;
        if (wr_data_i != CMD_CONFIRM) begin
          erase_err_q <= 1'b1;
          seq_err_q   <= 1'b1;
        end else if (LOCK_MASK[wr_blk_i]) begin
          erase_err_q <= 1'b1;
          lock_err_q  <= 1'b1;
        end else begin
          blk_q <= wr_blk_i;
        end
      end else begin
        case (wr_data_i)
          CMD_READ_ARRAY:  mode_q <= MODE_ARRAY;
          CMD_READ_ID:     mode_q <= MODE_ID;
          CMD_READ_STATUS: mode_q <= MODE_STATUS;
          CMD_CLEAR_ERR: begin
            erase_err_q <= 1'b0;
            seq_err_q   <= 1'b0;
            lock_err_q  <= 1'b0;
            mode_q      <= MODE_ARRAY;
          end
          CMD_ERASE_SETUP: begin
            pend_q <= 1'b1;
            mode_q <= MODE_STATUS;
          end
          default: ;
        endcase
      end
    end
  end

  assign mode_o   = mode_q;
  assign pend_o   = pend_q;
  assign blk_o    = blk_q;
  assign status_o = {!busy_i, 1'b0, erase_err_q, seq_err_q, 1'b0, 1'b0, lock_err_q, 1'b0};
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int BLOCKS       = 4,
  parameter int BLOCK_WORDS  = 8,
  parameter int DW           = 16,
  parameter int ERASE_CYCLES = 20,
  parameter int DEV_SEL      = 0,
  parameter logic [BLOCKS-1:0] LOCK_MASK = '0,
  parameter logic [DW-1:0]   INIT_BASE = 16'hA500,
  localparam int WORDS = BLOCKS * BLOCK_WORDS,
  localparam int AW    = $clog2(WORDS),
  localparam int BW    = $clog2(BLOCK_WORDS),
  localparam int BLK_W = AW - BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  rd_mode_e         rd_mode;
  logic             erase_busy, erase_done, erase_start, erase_pend;
  logic [BLK_W-1:0] erase_blk;
  logic [7:0]       status_byte;
  logic [DW-1:0]    arr_data, id_data, stat_snap_q, rd_data_q;
  logic             rd_en_q;
  logic             unused_wr_low;

  assign unused_wr_low = ^wr_addr_i[BW-1:0];

  flash_cmd_fsm #(.BLOCKS(BLOCKS), .LOCK_MASK(LOCK_MASK)) u_fsm (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .wr_blk_i (wr_addr_i[AW-1:BW]),
    .busy_i   (erase_busy),
    .mode_o   (rd_mode),
    .pend_o   (erase_pend),
    .start_o  (erase_start),
    .blk_o    (erase_blk),
    .status_o (status_byte)
  );

  flash_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .start_i (erase_start),
    .busy_o  (erase_busy),
    .done_o  (erase_done)
  );

  flash_array #(.BLOCKS(BLOCKS), .BLOCK_WORDS(BLOCK_WORDS), .DW(DW), .INIT_BASE(INIT_BASE)) u_array (
    .clk_i, .rst_ni,
    .rd_addr_i,
    .rd_data_o   (arr_data),
    .erase_i     (erase_done),
    .erase_blk_i (erase_blk)
  );

  always_comb begin
    if (rd_addr_i == AW'(0))      id_data = DW'(MFR_CODE);
    else if (rd_addr_i == AW'(1)) id_data = DW'(DEV_CODE_BASE + 16'(DEV_SEL));
    else                          id_data = '0;
  end

  // Status captured when the strobe is first seen, frozen while it stays high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_q     <= 1'b0;
      stat_snap_q <= '0;
      rd_data_q   <= '0;
    end else begin
      rd_en_q <= rd_en_i;
      if (rd_en_i && !rd_en_q) stat_snap_q <= DW'(status_byte);
      if (rd_en_i) begin
        case (rd_mode)
          MODE_ARRAY:  rd_data_q <= arr_data;
          MODE_ID:     rd_data_q <= id_data;
          default:     rd_data_q <= rd_en_q ? stat_snap_q : DW'(status_byte);
        endcase
      end
    end
  end

  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       busy,
  input logic       pend,
  input logic [7:0] status,
  input rd_mode_e   mode
);
  p_sticky_erase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[5] && !(wr_en_i && wr_data_i == CMD_CLEAR_ERR)) |=> status[5]);

  p_sticky_seq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[4] && !(wr_en_i && wr_data_i == CMD_CLEAR_ERR)) |=> status[4]);

  p_sticky_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[1] && !(wr_en_i && wr_data_i == CMD_CLEAR_ERR)) |=> status[1]);

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == CMD_CLEAR_ERR && !busy && !pend)
      |=> (status[5:1] == 5'b0 && mode == MODE_ARRAY));

  p_busy_from_confirm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wr_en_i && pend && wr_data_i == CMD_CONFIRM));

  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_en_i) |=> ($stable(mode) && $stable(status[5:0])));

  p_seq_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && wr_en_i && !busy && wr_data_i != CMD_CONFIRM)
      |=> (status[5] && status[4] && !busy && mode == MODE_STATUS));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .busy      (erase_busy),
  .pend      (erase_pend),
  .status    (status_byte),
  .mode      (rd_mode)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ERASE = 12;
  localparam int NV = 23;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [4:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  flash_cmd_ctrl #(
    .BLOCKS(4), .BLOCK_WORDS(8), .DW(16), .ERASE_CYCLES(ERASE),
    .DEV_SEL(2), .LOCK_MASK(4'b1000), .INIT_BASE(16'hA500)
  ) dut (.*);

  // {is_write, addr, data-or-expected}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 5'd0,  16'hA500},  // R2
    {1'b0, 5'd5,  16'hA505},  // R2
    {1'b1, 5'd0,  16'h0090},
    {1'b0, 5'd0,  16'h0089},  // R3
    {1'b0, 5'd1,  16'h88F3},  // R3
    {1'b0, 5'd2,  16'h0000},  // R3
    {1'b1, 5'd0,  16'h0033},  // R12 unknown code
    {1'b0, 5'd1,  16'h88F3},  // R12
    {1'b1, 5'd0,  16'h0070},
    {1'b0, 5'd3,  16'h0080},  // R7 status mode, ready
    {1'b1, 5'd0,  16'h00FF},
    {1'b0, 5'd31, 16'hA51F},  // R2
    {1'b1, 5'd0,  16'h0020},
    {1'b1, 5'd0,  16'h0055},  // R9 bad follow-up
    {1'b0, 5'd0,  16'h00B0},  // R9
    {1'b1, 5'd0,  16'h00FF},
    {1'b0, 5'd0,  16'hA500},  // R9 nothing erased
    {1'b1, 5'd0,  16'h0070},
    {1'b0, 5'd0,  16'h00B0},  // R4 sticky
    {1'b1, 5'd0,  16'h0050},  // R5
    {1'b0, 5'd0,  16'hA500},  // R5 back in array mode
    {1'b1, 5'd0,  16'h0070},
    {1'b0, 5'd0,  16'h0080}   // R5 flags cleared
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Tasks start and end on a falling edge
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk_i);
    d = rd_data_o;
    rd_en_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [15:0] d;
    logic        all_ff;
    idle(3);
    chk("R1 reset rd_data_o", rd_data_o, 16'h0000);
    rst_ni = 1'b1;
    idle(1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) wr(VEC[i][20:16], VEC[i][7:0]);
      else begin
        rd(VEC[i][20:16], d);
        chk($sformatf("table step %0d (R2,R3,R4,R5,R7,R9,R12)", i), d, VEC[i][15:0]);
      end
    end

    // Block 0 erase: busy read, ignored write, frozen snapshot
    wr(5'd3, 8'h20);
    wr(5'd2, 8'hD0);
    rd(5'd0, d);  chk("R7 busy right after confirm", d, 16'h0000);
    wr(5'd0, 8'hFF);
    rd(5'd0, d);  chk("R8 read array ignored while busy", d, 16'h0000);
    rd_en_i = 1'b1; rd_addr_i = 5'd0;
    idle(ERASE + 3);
    chk("R11 status frozen while strobe held", rd_data_o, 16'h0000);
    rd_en_i = 1'b0;
    idle(1);
    rd(5'd0, d);  chk("R7 ready after erase", d, 16'h0080);
    wr(5'd0, 8'hFF);
    all_ff = 1'b1;
    for (int w = 0; w < 8; w++) begin
      rd(5'(w), d);
      if (d !== 16'hFFFF) all_ff = 1'b0;
    end
    chk("R6 block 0 all ones", 16'(all_ff), 16'h0001);
    rd(5'd8, d);  chk("R6 block 1 untouched", d, 16'hA508);

    // Block 1: last busy cycle
    wr(5'd8, 8'h20);
    wr(5'd12, 8'hD0);
    idle(ERASE - 1);
    rd(5'd0, d);  chk("R7 busy at k=ERASE", d, 16'h0000);
    idle(2);
    wr(5'd0, 8'hFF);
    rd(5'd15, d); chk("R6 block 1 erased", d, 16'hFFFF);

    // Block 2: first ready cycle
    wr(5'd16, 8'h20);
    wr(5'd16, 8'hD0);
    idle(ERASE);
    rd(5'd0, d);  chk("R7 ready at k=ERASE+1", d, 16'h0080);

    // Protected block 3
    wr(5'd24, 8'h20);
    wr(5'd25, 8'hD0);
    rd(5'd0, d);  chk("R10 protect error flags", d, 16'h00A2);
    wr(5'd0, 8'hFF);
    rd(5'd25, d); chk("R10 protected block unchanged", d, 16'hA519);

    // Reset mid-run restores array and status
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    rd(5'd0, d);  chk("R1 array restored after reset", d, 16'hA500);
    wr(5'd0, 8'h70);
    rd(5'd0, d);  chk("R1 status after reset", d, 16'h0080);

    summary();
  end
endmodule